// File: doc/BRIEF.md
# Interrupt Status Aggregation Controller

This block gathers interrupt conditions from a network controller into one 32-bit status word and drives a single interrupt line to the CPU. Short event pulses from the DMA engines are latched in the low bits of the word. Level requests from six sub-units (coding layer, transmit MAC, receive MAC, MAC control, management interface, bus error) show up directly in a middle field. The top field always shows the current 13-bit transmit completion index, so the interrupt handler learns how far transmission has progressed from the same read.

Software reaches the block through a small register port with a two-bit select. Select 0 reads the status word and clears the latched DMA events. Select 1 reads the same word without side effects. Select 2 is the mask register, which can be read and written. Select 3 is a write-only acknowledge that clears chosen DMA events. The interrupt line comes from a two-state machine. It rests in `LINE_IDLE` and moves to `LINE_RAISED` (transition *raise*) once any unmasked condition is pending. It returns to `LINE_IDLE` (transition *drop*) once none is pending. In every other case it stays where it is.

Top module: `irq_agg_ctrl`

## Requirements
- R1: A cycle with `rst_n` low at the clock edge makes the latched events zero, the mask all ones, and `cpu_irq` low from the next cycle on.
- R2: A pulse on `dma_evt[k]` for k in {0,1,2,4,5,6} sets status bit k. Status bit 3 and bits 12:7 always read 0, and a pulse on `dma_evt[3]` has no effect.
- R3: A read (`reg_rd`=1) with `reg_sel`=0 returns the full status word in that cycle, combinationally. It then clears status bits 6:0 at the clock edge and leaves all other bits unchanged.
- R4: A read with `reg_sel`=1 returns the same word as select 0 and clears nothing.
- R5: Status bits 18:13 equal `sub_irq[5:0]` in the same cycle, bit 13 taking `sub_irq[0]`. Reads and acknowledges never change them.
- R6: Status bits 31:19 equal `tx_done_idx` in the same cycle.
- R7: A write (`reg_wr`=1) with `reg_sel`=3 clears each status bit in 6:0 whose `reg_wdata` bit is 1. Zero data bits and data bits 31:7 have no effect.
- R8: A write with `reg_sel`=2 stores `reg_wdata` as the mask, which reads back on select 2. A mask bit set to 1 keeps the matching status bit from driving `cpu_irq`.
- R9: `cpu_irq` is registered. In each cycle it equals the OR over bits 18:0 of (status AND NOT mask) from the previous cycle, so mask bits 31:19 have no effect on it.
- R10: If an event pulse arrives in the same cycle as a clearing read or an acknowledge that targets its bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_sel | input | 2 | Register select: 0 status with clear, 1 status without clear, 2 mask, 3 acknowledge |
| reg_rd | input | 1 | Read strobe; the data is valid in the same cycle |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (0 for select 3) |
| dma_evt | input | 7 | One-cycle DMA event pulses, bit k targets status bit k |
| sub_irq | input | 6 | Level interrupt requests from the sub-units |
| tx_done_idx | input | 13 | Current transmit completion index |
| cpu_irq | output | 1 | Interrupt line to the CPU |

## Verification
The bench builds the block with its default parameters: a 32-bit word, seven event bits with bit 3 reserved, six sub-unit sources placed at bit 13, and therefore a 13-bit index field. With these values one vector table can raise every event bit, the reserved one included. It can drive all six sources at once and sweep the index up to its largest value, 0x1FFF. It also sets up an event colliding with a clearing read or an acknowledge in the same cycle. Directed tests then measure the one-cycle lag of the interrupt line in both directions and confirm that reset restores the mask.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Register-port select codes; the numbering is seen by software.
    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_PEEK = 2'd1,
        SEL_MASK = 2'd2,
        SEL_ACK  = 2'd3
    } reg_sel_e;

    // States of the interrupt line controller.
    typedef enum logic {
        LINE_IDLE   = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_agg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        sel,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] stat_word,
    input  logic [DATA_W-1:0] mask_word,
    output logic              rd_clear,
    output logic              mask_we,
    output logic              ack_we,
    output logic [DATA_W-1:0] rdata
);

    reg_sel_e sel_e;
    assign sel_e = reg_sel_e'(sel);

    always_comb begin
        rd_clear = 1'b0;
        mask_we  = 1'b0;
        ack_we   = 1'b0;
        rdata    = '0;
        unique case (sel_e)
            SEL_STAT: begin
                rdata    = stat_word;
                rd_clear = rd;
            end
            SEL_PEEK: begin
                rdata = stat_word;
            end
            SEL_MASK: begin
                rdata   = mask_word;
                mask_we = wr;
            end
            SEL_ACK: begin
                ack_we = wr;
            end
            default: begin
                rdata = '0;
            end
        endcase
    end

endmodule

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
    parameter int EVT_N    = 7,
    parameter int RSVD_BIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt,
    input  logic [EVT_N-1:0] clr,
    output logic [EVT_N-1:0] q
);

    for (genvar g = 0; g < EVT_N; g++) begin : g_bit
        if (g == RSVD_BIT) begin : g_rsvd
            logic unused_rsvd;
            assign unused_rsvd = evt[g] ^ clr[g];
            assign q[g] = 1'b0;
        end else begin : g_live
            logic bit_q;
            // A set in the same cycle as a clear takes priority.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else if (evt[g]) begin
                    bit_q <= 1'b1;
                end else if (clr[g]) begin
                    bit_q <= 1'b0;
                end
            end
            assign q[g] = bit_q;
        end
    end

endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import irq_agg_pkg::*;
#(
    parameter int PEND_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PEND_W-1:0] pend,
    output logic              irq
);

    line_state_e state_q;
    line_state_e state_d;
    logic        any_pend;

    assign any_pend = |pend;

    // Next-state logic: raise / drop / hold.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE:   if (any_pend)  state_d = LINE_RAISED;
            LINE_RAISED: if (!any_pend) state_d = LINE_IDLE;
            default:     state_d = LINE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LINE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode.
    always_comb begin
        irq = 1'b0;
        unique case (state_q)
            LINE_IDLE:   irq = 1'b0;
            LINE_RAISED: irq = 1'b1;
            default:     irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
    import irq_agg_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int EVT_N    = 7,
    parameter int RSVD_BIT = 3,
    parameter int SUB_LSB  = 13,
    parameter int SUB_N    = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [1:0]                      reg_sel,
    input  logic                            reg_rd,
    input  logic                            reg_wr,
    input  logic [DATA_W-1:0]               reg_wdata,
    output logic [DATA_W-1:0]               reg_rdata,
    input  logic [EVT_N-1:0]                dma_evt,
    input  logic [SUB_N-1:0]                sub_irq,
    input  logic [DATA_W-SUB_LSB-SUB_N-1:0] tx_done_idx,
    output logic                            cpu_irq
);

    localparam int IDX_LSB = SUB_LSB + SUB_N;
    localparam int IDX_W   = DATA_W - IDX_LSB;
    localparam int PEND_W  = IDX_LSB;

    logic [EVT_N-1:0]  evt_q;
    logic [EVT_N-1:0]  evt_clr;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] mask_q;
    logic [PEND_W-1:0] pend;
    logic              rd_clear;
    logic              mask_we;
    logic              ack_we;

    irq_reg_decode #(.DATA_W(DATA_W)) u_dec (
        .sel       (reg_sel),
        .rd        (reg_rd),
        .wr        (reg_wr),
        .stat_word (stat_word),
        .mask_word (mask_q),
        .rd_clear  (rd_clear),
        .mask_we   (mask_we),
        .ack_we    (ack_we),
        .rdata     (reg_rdata)
    );

    // Clearing read wipes every event bit; acknowledge wipes the chosen ones.
    assign evt_clr = {EVT_N{rd_clear}} | (ack_we ? reg_wdata[EVT_N-1:0] : '0);

    irq_evt_latch #(.EVT_N(EVT_N), .RSVD_BIT(RSVD_BIT)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (dma_evt),
        .clr   (evt_clr),
        .q     (evt_q)
    );

    always_comb begin
        stat_word                       = '0;
        stat_word[EVT_N-1:0]            = evt_q;
        stat_word[IDX_LSB-1:SUB_LSB]    = sub_irq;
        stat_word[DATA_W-1:IDX_LSB]     = tx_done_idx[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (mask_we) begin
            mask_q <= reg_wdata;
        end
    end

    assign pend = stat_word[PEND_W-1:0] & ~mask_q[PEND_W-1:0];

    irq_line_fsm #(.PEND_W(PEND_W)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .irq   (cpu_irq)
    );

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int EVT_N    = 7,
    parameter int RSVD_BIT = 3,
    parameter int SUB_LSB  = 13,
    parameter int SUB_N    = 6
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [1:0]                      reg_sel,
    input logic                            reg_rd,
    input logic                            reg_wr,
    input logic [DATA_W-1:0]               reg_wdata,
    input logic [EVT_N-1:0]                dma_evt,
    input logic [SUB_N-1:0]                sub_irq,
    input logic [DATA_W-SUB_LSB-SUB_N-1:0] tx_done_idx,
    input logic                            cpu_irq,
    input logic [DATA_W-1:0]               stat_word,
    input logic [DATA_W-1:0]               mask_q
);

    localparam int IDX_LSB = SUB_LSB + SUB_N;
    localparam logic [EVT_N-1:0] LIVE = ~(EVT_N'(1) << RSVD_BIT);

    // R1: reset leaves the mask full and the line quiet.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '1) && !cpu_irq);

    // R2: reserved and unused low bits stay zero.
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_word[RSVD_BIT] && (stat_word[SUB_LSB-1:EVT_N] == '0));

    // R3: clearing read with no new event empties the event field.
    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == SEL_STAT && dma_evt == '0)
        |=> stat_word[EVT_N-1:0] == '0);

    // R4: non-clearing read loses no event bit.
    a_r4_peek_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == SEL_PEEK && !reg_wr)
        |=> (stat_word[EVT_N-1:0] & $past(stat_word[EVT_N-1:0]))
            == $past(stat_word[EVT_N-1:0]));

    // R5: sub-unit field follows its inputs.
    a_r5_sub_follow: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[IDX_LSB-1:SUB_LSB] == sub_irq);

    // R6: index field mirrors the completion index.
    a_r6_idx_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[DATA_W-1:IDX_LSB] == tx_done_idx);

    // R7: acknowledged bits are gone one cycle later.
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_ACK && dma_evt == '0)
        |=> (stat_word[EVT_N-1:0] & $past(reg_wdata[EVT_N-1:0])) == '0);

    // R8: a mask write is stored.
    a_r8_mask_store: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_MASK) |=> mask_q == $past(reg_wdata));

    // R9: interrupt line lags pending conditions by one cycle.
    a_r9_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cpu_irq == |($past(stat_word[IDX_LSB-1:0]) & ~$past(mask_q[IDX_LSB-1:0])));

    // R10: an arriving event is never lost to a simultaneous clear.
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((dma_evt & LIVE) != '0)
        |=> ($past(dma_evt & LIVE) & ~stat_word[EVT_N-1:0]) == '0);

endmodule

bind irq_agg_ctrl irq_agg_chk #(
    .DATA_W   (DATA_W),
    .EVT_N    (EVT_N),
    .RSVD_BIT (RSVD_BIT),
    .SUB_LSB  (SUB_LSB),
    .SUB_N    (SUB_N)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_sel     (reg_sel),
    .reg_rd      (reg_rd),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .dma_evt     (dma_evt),
    .sub_irq     (sub_irq),
    .tx_done_idx (tx_done_idx),
    .cpu_irq     (cpu_irq),
    .stat_word   (stat_word),
    .mask_q      (mask_q)
);

// File: tb/sim_irq_agg_ctrl.sv
module sim_irq_agg_ctrl;
    import irq_agg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  reg_sel;
    logic        reg_rd;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [6:0]  dma_evt;
    logic [5:0]  sub_irq;
    logic [12:0] tx_done_idx;
    logic        cpu_irq;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    irq_agg_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_sel     (reg_sel),
        .reg_rd      (reg_rd),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .dma_evt     (dma_evt),
        .sub_irq     (sub_irq),
        .tx_done_idx (tx_done_idx),
        .cpu_irq     (cpu_irq)
    );

    // op: 0 idle, 1 clearing read, 2 plain read, 3 mask write, 4 acknowledge
    typedef struct packed {
        logic [2:0]  op;
        logic [6:0]  evt;
        logic [5:0]  sub;
        logic [31:0] wdata;
        logic [18:0] exp_rd;
        logic [18:0] exp_st;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 7'h01, 6'h00, 32'h0000_0000, 19'h00000, 19'h00001, 1'b0}, // 0  R2 set, masked
        '{3'd3, 7'h00, 6'h00, 32'hFFFF_FFFE, 19'h00000, 19'h00001, 1'b1}, // 1  R8 unmask bit0
        '{3'd2, 7'h00, 6'h00, 32'h0000_0000, 19'h00001, 19'h00001, 1'b1}, // 2  R4 plain read
        '{3'd1, 7'h00, 6'h00, 32'h0000_0000, 19'h00001, 19'h00000, 1'b0}, // 3  R3 clearing read
        '{3'd0, 7'h76, 6'h00, 32'h0000_0000, 19'h00000, 19'h00076, 1'b0}, // 4  R2 five events
        '{3'd4, 7'h00, 6'h00, 32'h0000_0024, 19'h00000, 19'h00052, 1'b0}, // 5  R7 ack bits 2,5
        '{3'd0, 7'h08, 6'h00, 32'h0000_0000, 19'h00000, 19'h00052, 1'b0}, // 6  R2 reserved pulse
        '{3'd1, 7'h00, 6'h01, 32'h0000_0000, 19'h02052, 19'h02000, 1'b0}, // 7  R5 sub survives read
        '{3'd3, 7'h00, 6'h01, 32'hFFFF_DFFF, 19'h00000, 19'h02000, 1'b1}, // 8  R8 unmask bit13
        '{3'd0, 7'h00, 6'h00, 32'h0000_0000, 19'h00000, 19'h00000, 1'b0}, // 9  R5 source drops
        '{3'd3, 7'h00, 6'h20, 32'h0000_0000, 19'h00000, 19'h40000, 1'b1}, // 10 R8 unmask all
        '{3'd1, 7'h20, 6'h20, 32'h0000_0000, 19'h40000, 19'h40020, 1'b1}, // 11 R10 set vs read
        '{3'd4, 7'h40, 6'h20, 32'hFFFF_FFFF, 19'h00000, 19'h40040, 1'b1}, // 12 R10 set vs ack
        '{3'd4, 7'h00, 6'h20, 32'hFFFF_FF80, 19'h00000, 19'h40040, 1'b1}, // 13 R7 upper ack bits
        '{3'd4, 7'h00, 6'h00, 32'h0000_0040, 19'h00000, 19'h00000, 1'b0}, // 14 R7 ack bit6
        '{3'd0, 7'h7F, 6'h3F, 32'h0000_0000, 19'h00000, 19'h7E077, 1'b1}, // 15 R2 all inputs
        '{3'd3, 7'h00, 6'h3F, 32'h0007_FFFF, 19'h00000, 19'h7E077, 1'b0}, // 16 R8 mask 18:0
        '{3'd3, 7'h00, 6'h3F, 32'hFFF8_0000, 19'h00000, 19'h7E077, 1'b1}  // 17 R9 upper mask inert
    };

    function automatic string tag_of(int i);
        case (i)
            0, 4, 6, 15: return "R2";
            1, 8, 10, 16: return "R8";
            2:            return "R4";
            3:            return "R3";
            5, 13, 14:    return "R7";
            7, 9:         return "R5";
            11, 12:       return "R10";
            default:      return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic go_idle();
        reg_sel   = SEL_PEEK;
        reg_rd    = 1'b0;
        reg_wr    = 1'b0;
        reg_wdata = '0;
        dma_evt   = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n       = 1'b0;
        sub_irq     = '0;
        tx_done_idx = 13'h0A5C;
        go_idle();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R6: state right after reset
        #1;
        chk("R1 status", reg_rdata, {13'h0A5C, 19'h0});
        chk("R1 irq", {31'b0, cpu_irq}, 32'h0);
        reg_sel = SEL_MASK;
        #1;
        chk("R1 mask", reg_rdata, 32'hFFFF_FFFF);
        reg_sel = SEL_PEEK;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            sub_irq   = VEC[i].sub;
            dma_evt   = VEC[i].evt;
            reg_wdata = VEC[i].wdata;
            reg_rd    = (VEC[i].op == 3'd1) || (VEC[i].op == 3'd2);
            reg_wr    = (VEC[i].op == 3'd3) || (VEC[i].op == 3'd4);
            case (VEC[i].op)
                3'd1:    reg_sel = SEL_STAT;
                3'd3:    reg_sel = SEL_MASK;
                3'd4:    reg_sel = SEL_ACK;
                default: reg_sel = SEL_PEEK;
            endcase
            #1;
            if (VEC[i].op == 3'd1 || VEC[i].op == 3'd2)
                chk({tag_of(i), " read data"}, reg_rdata, {tx_done_idx, VEC[i].exp_rd});
            @(negedge clk);
            go_idle();
            @(negedge clk);
            #1;
            chk({tag_of(i), " status"}, reg_rdata, {tx_done_idx, VEC[i].exp_st});
            chk({tag_of(i), " irq"}, {31'b0, cpu_irq}, {31'b0, VEC[i].exp_irq});
        end

        // R6: largest index value
        tx_done_idx = 13'h1FFF;
        #1;
        chk("R6 index", reg_rdata, {13'h1FFF, 19'h7E077});

        // R8: mask read-back
        reg_sel = SEL_MASK;
        #1;
        chk("R8 mask readback", reg_rdata, 32'hFFF8_0000);
        reg_sel = SEL_PEEK;

        // R9: line drops one cycle after status empties
        @(negedge clk);
        sub_irq   = '0;
        reg_sel   = SEL_ACK;
        reg_wr    = 1'b1;
        reg_wdata = 32'h0000_007F;
        @(negedge clk);
        go_idle();
        #1;
        chk("R9 status empty", reg_rdata, {13'h1FFF, 19'h0});
        chk("R9 irq still high", {31'b0, cpu_irq}, 32'h1);
        @(negedge clk);
        #1;
        chk("R9 irq dropped", {31'b0, cpu_irq}, 32'h0);

        // R9: line rises one cycle after an event latches
        dma_evt = 7'h10;
        @(negedge clk);
        go_idle();
        #1;
        chk("R9 event latched", reg_rdata, {13'h1FFF, 19'h00010});
        chk("R9 irq not yet", {31'b0, cpu_irq}, 32'h0);
        @(negedge clk);
        #1;
        chk("R9 irq raised", {31'b0, cpu_irq}, 32'h1);

        // R1: reset in the middle of activity
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 events cleared", reg_rdata, {13'h1FFF, 19'h0});
        chk("R1 irq low", {31'b0, cpu_irq}, 32'h0);
        reg_sel = SEL_MASK;
        #1;
        chk("R1 mask restored", reg_rdata, 32'hFFFF_FFFF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule